// File: doc/BRIEF.md
# Trace-Driven Synaptic Weight Updater

This engine applies reward-gated learning to stored synapses. A queue holds the addresses of eligibility traces whose synapses earned a weight change. For each queued address the engine does four things in order. It reads the 36-bit signed trace value. It recovers the matching synapse address by subtracting a configured region offset, then reads the 32-bit synapse word. Finally it writes the word back, with the trace added to its 16-bit signed weight. The engine only runs while reward is asserted, so the weight change is exactly the trace value.

The sum is formed at 37 bits and then clamped to the 16-bit signed range, so even a trace far outside that range cannot wrap. The opcode and target bits above the weight are written back unchanged. The offset must exceed the synapse region size, for example 0x8000, so that the two regions never overlap. The queue is popped through a first-word-fall-through port, one entry at a time. The next entry is taken only after the write of the current entry has been accepted. Memory traffic uses a single request/grant port with a separate read-response strobe.

Top module: `syn_weight_updater`

## Requirements
- R1: After reset, with an empty queue, `busy`, `done`, `mem_req` and `q_pop` are all low.
- R2: `q_pop` is raised only while `q_empty` is low, for one cycle per update. The next pop happens only after the current update's write has been granted, so each update's three memory transactions follow its own pop.
- R3: After a pop, the first transaction is a read (`mem_we`=0) at the popped trace address. The value is taken from `mem_rdata[35:0]` as a signed two's-complement trace.
- R4: The second transaction is a read at (trace address − `cfg_offset`) modulo 2^23. Its word is taken from `mem_rdata[31:0]`.
- R5: The third transaction is a write (`mem_we`=1) to the synapse address. Its bits [15:0] hold the signed sum of the old weight (bits [15:0] of the synapse word) and the trace. A sum above 32767 is written as 32767 (0x7FFF).
- R6: A sum below −32768 is written as −32768 (0x8000).
- R7: Bits [31:16] of the written word equal bits [31:16] of the synapse word that was read.
- R8: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R9: `done` is high for exactly one cycle, in the cycle after each write grant. `busy` is high whenever the queue is non-empty or an update is in progress, and low otherwise.
- R10: Traces with magnitude far beyond 16 bits (for example ±2^34) saturate to the correct limit and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_offset | input | 23 | Distance from a synapse address to its trace address |
| q_empty | input | 1 | Trace-address queue is empty |
| q_addr | input | 23 | Head entry of the queue (valid while not empty) |
| q_pop | output | 1 | Removes the head entry at this clock edge |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 23 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted at this edge |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 36 | Read data (synapse word in bits [31:0]) |
| busy | output | 1 | Queue non-empty or update in progress |
| done | output | 1 | One-cycle pulse per completed update |

## Verification
A pop appears in the cycle after the engine first sees a non-empty queue, and the trace read request follows one cycle later. The synapse read is requested one cycle after the trace data returns. The write is requested one cycle after the synapse data returns, and `done` rises one cycle after the write grant. The bench does not count fixed cycles. Its memory responder grants and answers at every falling edge, with a grant delay and read latency chosen per scenario. It logs each transaction at the edge where the grant is given, and records where each pop falls within that log. Each scenario waits for `busy` to fall and then compares the log against values computed from the requirements. Varying the delays exercises the request-hold and ordering rules.

// File: rtl/syn_weight_updater.sv
module syn_weight_updater #(
  parameter int ADDR_W  = 23,
  parameter int TRACE_W = 36,
  parameter int WORD_W  = 32,
  parameter int WT_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_offset,
  input  logic               q_empty,
  input  logic [ADDR_W-1:0]  q_addr,
  output logic               q_pop,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [TRACE_W-1:0] mem_rdata,
  output logic               busy,
  output logic               done
);
  localparam int SUM_W = TRACE_W + 1;
  localparam logic signed [SUM_W-1:0] WMAX = SUM_W'((1 << (WT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] WMIN = ~WMAX;

  typedef enum logic [2:0] {
    IDLE, POP, RD_TRACE, WAIT_TRACE, RD_SYN, WAIT_SYN, WRITE, DONE
  } state_t;

  state_t              st;
  logic [ADDR_W-1:0]   tr_addr;
  logic [TRACE_W-1:0]  trace_q;
  logic [WORD_W-1:0]   syn_q;
  logic signed [SUM_W-1:0] sum;
  logic [WT_W-1:0]     new_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      tr_addr <= '0;
      trace_q <= '0;
      syn_q   <= '0;
    end else begin
      case (st)
        IDLE:       if (!q_empty) st <= POP;
        POP:        begin tr_addr <= q_addr; st <= RD_TRACE; end
        RD_TRACE:   if (mem_gnt) st <= WAIT_TRACE;
        WAIT_TRACE: if (mem_rvalid) begin trace_q <= mem_rdata; st <= RD_SYN; end
        RD_SYN:     if (mem_gnt) st <= WAIT_SYN;
        WAIT_SYN:   if (mem_rvalid) begin syn_q <= mem_rdata[WORD_W-1:0]; st <= WRITE; end
        WRITE:      if (mem_gnt) st <= DONE;
        default:    st <= IDLE;
      endcase
    end
  end

  assign sum = $signed({{(SUM_W-WT_W){syn_q[WT_W-1]}}, syn_q[WT_W-1:0]})
             + $signed({trace_q[TRACE_W-1], trace_q});

  always_comb begin
    if (sum > WMAX)      new_w = WMAX[WT_W-1:0];
    else if (sum < WMIN) new_w = WMIN[WT_W-1:0];
    else                 new_w = sum[WT_W-1:0];
  end

  assign q_pop     = (st == POP);
  assign mem_req   = (st == RD_TRACE) || (st == RD_SYN) || (st == WRITE);
  assign mem_we    = (st == WRITE);
  assign mem_addr  = (st == RD_TRACE) ? tr_addr : tr_addr - cfg_offset;
  assign mem_wdata = {syn_q[WORD_W-1:WT_W], new_w};
  assign busy      = (st != IDLE) || !q_empty;
  assign done      = (st == DONE);

  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> !q_empty);

  assert_pop_then_trace_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> (mem_req && !mem_we));

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));

  assert_write_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_gnt) |=> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_syn_weight_updater.sv
`timescale 1ns/1ps
module tb_syn_weight_updater;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] cfg_offset = 23'h8000;
  logic        q_empty;
  logic [22:0] q_addr;
  logic        q_pop;
  logic        mem_req, mem_we;
  logic [22:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [35:0] mem_rdata = '0;
  logic        busy, done;

  always #2.5 clk = ~clk;

  syn_weight_updater dut (.*);

  int checks = 0, fails = 0;

  logic [22:0] qarr [0:15];
  int qhead = 0, qtail = 0;
  assign q_empty = (qhead == qtail);
  assign q_addr  = qarr[qhead[3:0]];

  logic [35:0] mem [int];
  int gnt_delay = 0, rd_lat = 1;
  int log_n = 0, pop_n = 0, done_n = 0;
  logic [22:0] log_addr [0:63];
  logic        log_we   [0:63];
  logic [31:0] log_data [0:63];
  int          pop_at   [0:15];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] rd_mem(input logic [22:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return '0;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] old, input logic [35:0] tr);
    longint s;
    s = longint'($signed(old[15:0])) + longint'($signed(tr));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return {old[31:16], 16'(s)};
  endfunction

  initial begin : responder
    bit pop_seen = 0;
    int wcnt = 0, rv_cnt = 0;
    logic [35:0] rv_data = '0;
    logic [22:0] p_addr = '0;
    logic        p_we = 0;
    logic [31:0] p_data = '0;
    forever begin
      @(negedge clk);
      if (pop_seen) qhead++;
      pop_seen = q_pop;
      if (q_pop) begin pop_at[pop_n[3:0]] = log_n; pop_n++; end
      if (done) done_n++;
      mem_rvalid = 1'b0;
      if (rv_cnt > 0) begin
        rv_cnt--;
        if (rv_cnt == 0) begin mem_rvalid = 1'b1; mem_rdata = rv_data; end
      end
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        log_addr[log_n[5:0]] = p_addr; log_we[log_n[5:0]] = p_we; log_data[log_n[5:0]] = p_data;
        log_n++;
        if (p_we) mem[int'(p_addr)] = {4'h0, p_data};
        else begin rv_cnt = rd_lat; rv_data = rd_mem(p_addr); end
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= gnt_delay) begin
          mem_gnt = 1'b1; p_addr = mem_addr; p_we = mem_we; p_data = mem_wdata;
        end else wcnt++;
      end
    end
  end

  task automatic clear_logs();
    log_n = 0; pop_n = 0; done_n = 0;
  endtask

  task automatic push(input logic [22:0] a);
    qarr[qtail[3:0]] = a; qtail++;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_update(input int k, input logic [22:0] ta, input logic [31:0] old,
                              input logic [35:0] tr, input string rq);
    logic [22:0] sa;
    int b;
    sa = ta - cfg_offset;
    b = 3 * k;
    chk(log_we[b] == 0 && log_addr[b] == ta, "R3", longint'(log_addr[b]), longint'(ta));
    chk(log_we[b+1] == 0 && log_addr[b+1] == sa, "R4", longint'(log_addr[b+1]), longint'(sa));
    chk(log_we[b+2] == 1 && log_addr[b+2] == sa, "R7", longint'(log_addr[b+2]), longint'(sa));
    chk(log_data[b+2] == exp_word(old, tr), rq, longint'(log_data[b+2]),
        longint'(exp_word(old, tr)));
  endtask

  task automatic single(input logic [22:0] ta, input logic [31:0] old, input logic [35:0] tr,
                        input string rq);
    clear_logs();
    mem[int'(ta)] = tr;
    mem[int'(23'(ta - cfg_offset))] = {4'h0, old};
    push(ta);
    wait_idle();
    chk(log_n == 3, "R2", log_n, 3);
    check_update(0, ta, old, tr, rq);
    chk(done_n == 1, "R9", done_n, 1);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_req && !q_pop, "R1",
        longint'({busy, done, mem_req, q_pop}), 0);
  endtask

  task automatic t_basic();
    single(23'h8001 + 23'h8000, 32'hABCD_01F4, 36'd100, "R5");
    single(23'h9000, 32'h1234_0032, -36'sd200, "R5");
  endtask

  task automatic t_saturate();
    single(23'h9100, 32'h0F0F_7D00, 36'd1000, "R5");
    single(23'h9101, 32'hF0F0_8300, -36'sd1000, "R6");
  endtask

  task automatic t_huge();
    single(23'h9200, 32'h5555_FFFB, 36'sh4_0000_0000, "R10");
    single(23'h9201, 32'hAAAA_0005, -36'sh4_0000_0000, "R10");
  endtask

  task automatic t_offset_wrap();
    cfg_offset = 23'h40_0000;
    single(23'h00_0010, 32'h7777_0001, 36'd2, "R4");
    cfg_offset = 23'h8000;
  endtask

  task automatic t_burst();
    logic [22:0] ta [0:2];
    logic [31:0] ow [0:2];
    logic [35:0] tv [0:2];
    clear_logs();
    gnt_delay = 2; rd_lat = 3;
    ta[0] = 23'hA000; ow[0] = 32'h0102_0010; tv[0] = 36'd5;
    ta[1] = 23'hA001; ow[1] = 32'h0304_7FF0; tv[1] = 36'd64;
    ta[2] = 23'hA002; ow[2] = 32'h0506_FF00; tv[2] = -36'sd7;
    for (int i = 0; i < 3; i++) begin
      mem[int'(ta[i])] = tv[i];
      mem[int'(23'(ta[i] - cfg_offset))] = {4'h0, ow[i]};
      push(ta[i]);
    end
    @(negedge clk);
    chk(busy == 1'b1, "R9", longint'(busy), 1);
    wait_idle();
    chk(!busy, "R9", longint'(busy), 0);
    chk(log_n == 9 && pop_n == 3, "R2", log_n * 100 + pop_n, 903);
    for (int i = 0; i < 3; i++) begin
      chk(pop_at[i] == 3 * i, "R2", pop_at[i], 3 * i);
      check_update(i, ta[i], ow[i], tv[i], i == 1 ? "R5" : "R8");
    end
    chk(done_n == 3, "R9", done_n, 3);
    gnt_delay = 0; rd_lat = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_saturate();
    t_huge();
    t_offset_wrap();
    t_burst();
    t_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule